// File: doc/BRIEF.md
# Byte Serial Transceiver with Echo

This block moves one byte at a time over a four-wire synchronous serial link: serial clock, select, data toward the block and data away from it. It acts as master or slave. As master it makes the serial clock from the system clock through a programmable divider, drives the select line low for the whole transfer and shifts a byte out while it shifts a byte in. As slave it follows an external clock and select line, each passed through a synchronizer and edge detector, and answers with a byte taken from the parallel side when select goes active.

Two configuration bits set the clock behaviour. `cfg_idle_hi` sets the level the serial clock rests at. `cfg_alt` picks the capture edge: 0 captures on the rising edge and changes output on the falling edge, 1 does the reverse. A third bit, `cfg_echo`, makes a selected slave copy its data input straight to its data output instead of sending its own byte. The parallel side offers a byte and a start pulse. It returns the received byte, a one-cycle `done` pulse and `busy`.

The controller has five states. `ST_IDLE` waits. It goes to `ST_LEAD` on start in master mode, or to `ST_SLAVE` when select goes active in slave mode. `ST_LEAD` holds the first data bit for half a serial period and moves to `ST_CLOCK` on the first clock edge. `ST_CLOCK` makes the remaining fifteen edges and moves to `ST_TAIL` after the last one. `ST_TAIL` keeps select low for a further half period and returns to `ST_IDLE`. `ST_SLAVE` returns to `ST_IDLE` once the synchronized select goes inactive.

Top module: `sbx_top`

## Requirements
- R1: In master mode, `sck_o` rests at the level of `cfg_idle_hi` (0 = low, 1 = high) outside a transfer. Each transfer makes exactly 16 clock transitions and leaves the clock at its resting level.
- R2: With `cfg_alt` = 0, data is captured on the rising clock edge and the outgoing data changes only on falling edges.
- R3: With `cfg_alt` = 1, data is captured on the falling clock edge and the outgoing data changes only on rising edges.
- R4: Eight bits move per transfer, most significant bit first, in both directions. `rx_byte` holds the eight captured bits, the first captured bit at bit 7.
- R5: In master mode, every clock phase lasts H = max(`cfg_div`, 4) / 2 system clocks, with integer division. A divider below 4 behaves as 4.
- R6: In master mode, `cs_n_o` goes low in the cycle after start is sampled. The first clock transition comes H cycles later, with the first data bit already on `sdo`. `cs_n_o` returns high H cycles after the 16th transition.
- R7: `done` is high for exactly one cycle, in the cycle after the eighth capture edge. `rx_byte` is valid in that cycle. `busy` is high for the whole transfer and low in idle.
- R8: In slave mode, `sdo_oe` is low whenever `cs_n_i` is high. It is high while select is active, starting within three cycles of select going low.
- R9: In slave mode with `cfg_echo` = 1 and select active, `sdo` follows `sdi` without a register, and the transmit byte is not sent.
- R10: `start` is ignored while a transfer is running and in slave mode, and `cfg_echo` has no effect in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_idle_hi | input | 1 | Clock resting level |
| cfg_alt | input | 1 | 0 = capture on rising edge, 1 = capture on falling edge |
| cfg_echo | input | 1 | Slave copies data input to data output |
| cfg_div | input | DIV_W | Master clock divider, in system clocks per serial period |
| tx_byte | input | DATA_W | Byte to send |
| start | input | 1 | Master start request |
| rx_byte | output | DATA_W | Received byte |
| done | output | 1 | One-cycle end-of-byte pulse |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received in slave mode |
| cs_n_o | output | 1 | Select driven in master mode, active low |
| cs_n_i | input | 1 | Select received in slave mode, active low |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out of the block |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
A wrong state or edge count in the master controller shows up on `sck_o` and `cs_n_o` within one half period. The result is a phase of the wrong length, a 15th or 17th transition, a clock left away from its resting level, or a select that releases early. A wrong capture-edge choice or transmit-shift choice changes the bits seen on `sdo` at the capture edges, and `rx_byte` is wrong at the very next `done`. A slave stuck in or out of `ST_SLAVE` shows at once on `sdo_oe`, or as a missing `done` at the end of the byte.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLOCK,
        ST_TAIL,
        ST_SLAVE
    } sbx_state_e;

endpackage

// File: rtl/sbx_tick.sv
// Half-period timer for master mode: one tick every max(div,MIN_DIV)/2 clocks.
module sbx_tick #(
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
    localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

    logic [DIV_W-1:0] eff_div;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;

    assign eff_div = (div < MIN_V) ? MIN_V : div;
    assign half    = eff_div >> 1;
    assign tick    = !restart && (cnt >= half - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

    // R5: two ticks are always at least two clocks apart
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sbx_sync.sv
// Synchronizer for the slave pins plus clock edge detection.
module sbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic sdi_pin,
    output logic cs_act,
    output logic sdi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sdi_p;
    logic              sck_prev;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sck_p <= '0;
                cs_p  <= '1;
                sdi_p <= '0;
            end else begin
                sck_p <= sck_pin;
                cs_p  <= cs_n_pin;
                sdi_p <= sdi_pin;
            end
        end
    end else begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sck_p <= '0;
                cs_p  <= '1;
                sdi_p <= '0;
            end else begin
                sck_p <= {sck_p[STAGES-2:0], sck_pin};
                cs_p  <= {cs_p[STAGES-2:0], cs_n_pin};
                sdi_p <= {sdi_p[STAGES-2:0], sdi_pin};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= sck_p[STAGES-1];
        end
    end

    assign cs_act   = !cs_p[STAGES-1];
    assign sdi_s    = sdi_p[STAGES-1];
    assign sck_rise = sck_p[STAGES-1] && !sck_prev;
    assign sck_fall = !sck_p[STAGES-1] && sck_prev;

endmodule

// File: rtl/sbx_shift.sv
// Transmit and receive shift registers, bit counter and end-of-byte pulse.
module sbx_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              sample_ev,
    input  logic              change_ev,
    input  logic              late_phase,
    input  logic              din,
    output logic              sdo_bit,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [CNT_W-1:0]  cnt;
    logic              first_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr      <= '0;
            rx_sr      <= '0;
            cnt        <= '0;
            first_seen <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                tx_sr      <= tx_data;
                cnt        <= '0;
                first_seen <= 1'b0;
            end else begin
                if (sample_ev && (cnt != FULL)) begin
                    rx_sr <= {rx_sr[DATA_W-2:0], din};
                    cnt   <= cnt + CNT_W'(1);
                    done  <= (cnt == LAST);
                end
                if (change_ev) begin
                    // in the late phase the first change edge only presents the MSB
                    if (late_phase && !first_seen) begin
                        first_seen <= 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sdo_bit = tx_sr[DATA_W-1];
    assign rx_data = rx_sr;

    // R7: the end-of-byte pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the pulse only comes once all bits are captured
    p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt == FULL));

endmodule

// File: rtl/sbx_top.sv
module sbx_top #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned MIN_DIV     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_idle_hi,
    input  logic              cfg_alt,
    input  logic              cfg_echo,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              start,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              busy,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    output logic              cs_n_o,
    input  logic              cs_n_i,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    import sbx_pkg::*;

    localparam int unsigned EDGES  = 2 * DATA_W;
    localparam int unsigned EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    sbx_state_e        state;
    sbx_state_e        state_nx;
    logic [EDGE_W-1:0] edge_cnt;
    logic              sck_r;
    logic              restart;
    logic              tick;
    logic              cs_act;
    logic              sdi_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              m_edge;
    logic              lead_ev;
    logic              trail_ev;
    logic              sample_on_lead;
    logic              sample_ev;
    logic              change_ev;
    logic              load;
    logic              din;
    logic              sdo_bit;
    logic              master_sel;

    sbx_tick #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div     (cfg_div),
        .tick    (tick)
    );

    sbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (sck_i),
        .cs_n_pin (cs_n_i),
        .sdi_pin  (sdi),
        .cs_act   (cs_act),
        .sdi_s    (sdi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cfg_master && start) begin
                    state_nx = ST_LEAD;
                end else if (!cfg_master && cs_act) begin
                    state_nx = ST_SLAVE;
                end
            end
            ST_LEAD: begin
                if (tick) state_nx = ST_CLOCK;
            end
            ST_CLOCK: begin
                if (tick && (edge_cnt == LAST_EDGE)) state_nx = ST_TAIL;
            end
            ST_TAIL: begin
                if (tick) state_nx = ST_IDLE;
            end
            ST_SLAVE: begin
                if (!cs_act || cfg_master) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // edge events: leading = away from rest level, trailing = back to it
    assign master_sel     = (state == ST_LEAD) || (state == ST_CLOCK) || (state == ST_TAIL);
    assign restart        = !master_sel;
    assign m_edge         = tick && ((state == ST_LEAD) || (state == ST_CLOCK));
    assign lead_ev        = (m_edge && !edge_cnt[0]) ||
                            ((state == ST_SLAVE) && (cfg_idle_hi ? sck_fall : sck_rise));
    assign trail_ev       = (m_edge && edge_cnt[0]) ||
                            ((state == ST_SLAVE) && (cfg_idle_hi ? sck_rise : sck_fall));
    assign sample_on_lead = (cfg_alt == cfg_idle_hi);
    assign sample_ev      = sample_on_lead ? lead_ev : trail_ev;
    assign change_ev      = sample_on_lead ? trail_ev : lead_ev;
    assign load           = (state == ST_IDLE) &&
                            ((state_nx == ST_LEAD) || (state_nx == ST_SLAVE));
    assign din            = cfg_master ? sdi : sdi_s;

    // master clock and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_r    <= 1'b0;
            edge_cnt <= '0;
        end else if (state == ST_IDLE) begin
            sck_r    <= cfg_idle_hi;
            edge_cnt <= '0;
        end else if (m_edge) begin
            sck_r    <= !sck_r;
            edge_cnt <= edge_cnt + EDGE_W'(1);
        end
    end

    sbx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .tx_data    (tx_byte),
        .sample_ev  (sample_ev),
        .change_ev  (change_ev),
        .late_phase (!sample_on_lead),
        .din        (din),
        .sdo_bit    (sdo_bit),
        .rx_data    (rx_byte),
        .done       (done)
    );

    // outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        cs_n_o = !master_sel;
        sck_o  = sck_r;
        sck_oe = cfg_master;
        sdo    = (!cfg_master && cfg_echo) ? sdi : sdo_bit;
        sdo_oe = cfg_master || ((state == ST_SLAVE) && !cs_n_i);
    end

    // R1: a finished master transfer leaves the clock at rest
    p_sck_idle_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $fell(busy)) |-> (sck_o == cfg_idle_hi));

    // R6: the master clock only moves while select is driven low
    p_sck_only_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(busy) && !$stable(sck_o)) |-> !cs_n_o);

    // R7: the end-of-byte pulse follows a capture edge
    p_done_after_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sample_ev));

endmodule

// File: tb/sbx_top_tb_top.sv
module sbx_top_tb_top;

    localparam int HP = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1;
    logic       cfg_idle_hi = 1'b0;
    logic       cfg_alt = 1'b0;
    logic       cfg_echo = 1'b0;
    logic [7:0] cfg_div = 8'd4;
    logic [7:0] tx_byte = 8'h00;
    logic       start = 1'b0;
    logic [7:0] rx_byte;
    logic       done;
    logic       busy;
    logic       sck_o;
    logic       sck_oe;
    logic       sck_i = 1'b0;
    logic       cs_n_o;
    logic       cs_n_i = 1'b1;
    logic       sdi;
    logic       sdo;
    logic       sdo_oe;
    logic       sdi_drv = 1'b0;
    logic       sdi_lb = 1'b0;
    logic       loopback = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    byte unsigned exp_q[$];
    byte unsigned mon_e;
    logic prev_done = 1'b0;

    always #2 clk = ~clk;

    assign sdi = loopback ? sdi_lb : sdi_drv;
    always @(negedge clk) sdi_lb <= sdo;

    sbx_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_master(cfg_master), .cfg_idle_hi(cfg_idle_hi), .cfg_alt(cfg_alt),
        .cfg_echo(cfg_echo), .cfg_div(cfg_div),
        .tx_byte(tx_byte), .start(start), .rx_byte(rx_byte), .done(done), .busy(busy),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
        .cs_n_o(cs_n_o), .cs_n_i(cs_n_i),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && prev_done) check(1'b0, "R7 done longer than one cycle", 1, 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    check(rx_byte == mon_e, "R4 received byte", int'(rx_byte), int'(mon_e));
                end
            end
        end
        prev_done <= done;
    end

    task automatic master_xfer(input bit idle_hi, input bit alt, input int div,
                               input byte unsigned tx, input bit inject);
        int h;
        int run;
        int edges;
        int samp;
        byte unsigned got;
        bit prev;
        h = ((div < 4) ? 4 : div) / 2;
        @(negedge clk);
        cfg_master = 1'b1; cfg_idle_hi = idle_hi; cfg_alt = alt;
        cfg_div = div[7:0]; loopback = 1'b1;
        repeat (3) @(negedge clk);
        check(sck_o == idle_hi, "R1 clock at rest before start", int'(sck_o), int'(idle_hi));
        check(busy == 1'b0, "R7 idle not busy", int'(busy), 0);
        exp_q.push_back(tx);
        tx_byte = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cs_n_o == 1'b0, "R6 select low after start", int'(cs_n_o), 0);
        check(busy == 1'b1, "R7 busy during transfer", int'(busy), 1);
        run = 0; edges = 0; samp = 0; got = 8'h00; prev = idle_hi;
        for (int guard = 0; guard < 4000; guard++) begin
            if (cs_n_o) begin
                check(run == h, "R6 select release delay", run, h);
                break;
            end
            if (sck_o != prev) begin
                if (edges == 0) check(run == h, "R6 first edge delay", run, h);
                else            check(run == h, "R5 clock phase length", run, h);
                edges++;
                run = 1;
                if (sck_o == !alt) begin
                    samp++;
                    got = {got[6:0], sdo};
                    if (samp == 8) check(done == 1'b1, "R7 done after eighth capture", int'(done), 1);
                end
                prev = sck_o;
            end else begin
                run++;
            end
            if (inject && edges == 5) begin
                tx_byte = ~tx; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(edges == 16, "R1 sixteen clock transitions", edges, 16);
        check(sck_o == idle_hi, "R1 clock back at rest", int'(sck_o), int'(idle_hi));
        check(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
        if (alt) check(got == tx, "R3 bits at falling edges", int'(got), int'(tx));
        else     check(got == tx, "R2 bits at rising edges", int'(got), int'(tx));
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R7 one done per transfer", exp_q.size(), 0);
        check(cs_n_o == 1'b1, "R10 no extra transfer", int'(cs_n_o), 1);
    endtask

    task automatic slave_xfer(input bit idle_hi, input bit alt, input bit echo,
                              input byte unsigned m, input byte unsigned s);
        bit samp_lead;
        int bi;
        byte unsigned got;
        byte unsigned want;
        @(negedge clk);
        cfg_master = 1'b0; cfg_idle_hi = idle_hi; cfg_alt = alt; cfg_echo = echo;
        loopback = 1'b0; sck_i = idle_hi; cs_n_i = 1'b1; sdi_drv = 1'b0; tx_byte = s;
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b0, "R8 output floats while deselected", int'(sdo_oe), 0);
        check(sck_oe == 1'b0, "R10 slave does not drive clock", int'(sck_oe), 0);
        exp_q.push_back(m);
        samp_lead = (alt == idle_hi);
        bi = 7;
        got = 8'h00;
        cs_n_i = 1'b0;
        if (samp_lead) sdi_drv = m[7];
        repeat (HP) @(negedge clk);
        check(sdo_oe == 1'b1, "R8 output driven when selected", int'(sdo_oe), 1);
        for (int e = 0; e < 16; e++) begin
            bit lead;
            lead = (e % 2 == 0);
            if (lead == samp_lead) got = {got[6:0], sdo};
            sck_i = ~sck_i;
            if (lead != samp_lead) begin
                if (samp_lead) begin
                    bi--;
                    if (bi >= 0) sdi_drv = m[bi];
                end else begin
                    sdi_drv = m[bi];
                    bi--;
                end
            end
            repeat (HP) @(negedge clk);
            if (echo) check(sdo == sdi_drv, "R9 echo follows input", int'(sdo), int'(sdi_drv));
        end
        want = echo ? m : s;
        if (echo)     check(got == want, "R9 echoed byte", int'(got), int'(want));
        else if (alt) check(got == want, "R3 slave bits at falling edges", int'(got), int'(want));
        else          check(got == want, "R2 slave bits at rising edges", int'(got), int'(want));
        check(exp_q.size() == 0, "R7 slave done produced", exp_q.size(), 0);
        cs_n_i = 1'b1;
        @(negedge clk);
        check(sdo_oe == 1'b0, "R8 float on release", int'(sdo_oe), 0);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R7 slave idle after release", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_test();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7 reset not busy", int'(busy), 0);
        check(done == 1'b0, "R7 reset no done", int'(done), 0);
        check(cs_n_o == 1'b1, "R6 reset select high", int'(cs_n_o), 1);
        check(sck_o == 1'b0, "R1 reset clock at rest", int'(sck_o), 0);

        master_xfer(1'b0, 1'b0, 4,  8'hA5, 1'b0);
        master_xfer(1'b0, 1'b1, 6,  8'h3C, 1'b0);
        master_xfer(1'b1, 1'b0, 2,  8'h81, 1'b0);   // R5 clamp of small divider
        master_xfer(1'b1, 1'b1, 10, 8'h5E, 1'b0);
        master_xfer(1'b0, 1'b1, 7,  8'h0F, 1'b0);
        master_xfer(1'b0, 1'b0, 4,  8'h96, 1'b1);   // R10 start while busy
        cfg_echo = 1'b1;
        master_xfer(1'b1, 1'b0, 4,  8'h6D, 1'b0);   // R10 echo ignored as master
        cfg_echo = 1'b0;

        slave_xfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5A);
        slave_xfer(1'b0, 1'b1, 1'b0, 8'h17, 8'hE8);
        slave_xfer(1'b1, 1'b0, 1'b0, 8'h99, 8'h24);
        slave_xfer(1'b1, 1'b1, 1'b0, 8'h40, 8'hB1);
        slave_xfer(1'b0, 1'b0, 1'b1, 8'hB2, 8'hFF);
        slave_xfer(1'b1, 1'b1, 1'b1, 8'h4D, 8'h00);

        // R10: start in slave mode does nothing
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R10 start ignored in slave mode", int'(busy), 0);
        check(cs_n_o == 1'b1, "R10 no select in slave mode", int'(cs_n_o), 1);
        check(exp_q.size() == 0, "R10 no done in slave mode", exp_q.size(), 0);

        finish_test();
    end

endmodule